// File: doc/BRIEF.md
# Four-Channel DMA Programming Register Block

This block is the byte-wide I/O register file through which a processor programs a four-channel DMA controller. A 4-bit port number, a write strobe and a read strobe select among per-channel 16-bit address and count registers, and among a set of control ports: command, mode, software request, single-channel mask, all-channel mask and status. There are also three command ports where the write itself is the action. Each 16-bit register is reached one byte at a time, low byte first. A single byte-pointer flip-flop, shared by all sixteen-bit registers, picks the byte.

The transfer engine gets every channel's base and current address and count, its decoded mode fields, its mask bit and its software request, together with the command byte. In return it drives per-channel update strobes with new current address and count values, terminal-count pulses and hardware request levels. There is no data stream at this boundary: every pin is a plain control or status level, and no valid/ready back-pressure applies. Read data is combinational from the addressed state while the read strobe is high. The side effects of a read (a pointer toggle, or clearing the terminal-count flags) take effect at the clock edge that ends the read.

Top module: `dmac_regfile`

## Requirements
- R1: After reset all four masks are set, the command byte, the software requests, the terminal-count flags, the byte pointer and every address and count register are zero.
- R2: A write to port 2n (address) or port 2n+1 (count), with n = 0..3, loads the byte selected by the pointer into both the base and the current copy of channel n's register. The low byte is bits 7:0 and the high byte is bits 15:8.
- R3: A read of ports 0..7 returns the byte of the current copy that the pointer selects. Every read or write of ports 0..7 toggles the one shared pointer, whatever the channel or register.
- R4: Any write to port 0xC returns the pointer to the low byte.
- R5: Any write to port 0xD sets all masks and clears the command byte, the software requests, the terminal-count flags and the pointer. Address, count and mode registers keep their values.
- R6: A write to port 0xE clears all masks. A write to port 0xA sets channel wdata[1:0]'s mask to wdata[2]. A write to port 0xF loads all masks from wdata[3:0], with bit i going to channel i.
- R7: A write to port 0x9 sets channel wdata[1:0]'s software request to wdata[2].
- R8: A write to port 0xB stores the mode of channel wdata[1:0]. Bits 3:2 are the transfer type, exported as 00 verify, 01 write or 10 read, with 11 exported as 00. Bit 4 is auto-initialise, bit 5 is increment, and bits 7:6 are the operating mode (00 demand, 01 single, 10 block, 11 cascade).
- R9: A read of port 0x8 returns the terminal-count flags in bits 3:0 and the pending flags (software or hardware request) in bits 7:4, with channel i in bit i and bit 4+i. The read clears the terminal-count flags, but a terminal-count pulse in the same cycle leaves its flag set.
- R10: An engine update strobe replaces a channel's current address and count and leaves the base copies unchanged. A host write to one of those registers in the same cycle wins for that register.
- R11: A write to port 0x8 loads the command byte exported to the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Port number |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the addressed port |
| cfg_cmd | output | 8 | Command byte |
| cfg_xfer | output | 8 | Transfer type, 2 bits per channel |
| cfg_auto | output | 4 | Auto-initialise per channel |
| cfg_inc | output | 4 | Address increment per channel |
| cfg_opmode | output | 8 | Operating mode, 2 bits per channel |
| ch_mask | output | 4 | Channel masks |
| ch_swreq | output | 4 | Software requests |
| ch_base_addr | output | 64 | Base addresses, 16 bits per channel |
| ch_base_cnt | output | 64 | Base counts |
| ch_cur_addr | output | 64 | Current addresses |
| ch_cur_cnt | output | 64 | Current counts |
| eng_upd | input | 4 | Per-channel current-value update strobe |
| eng_addr | input | 64 | New current addresses |
| eng_cnt | input | 64 | New current counts |
| eng_tc | input | 4 | Terminal-count pulses |
| eng_hwreq | input | 4 | Hardware request levels |

## Verification
Two pairs of functions can land in one cycle. A status read can meet a terminal-count pulse, and a host byte write can meet an engine update on the same channel. The bench drives both inputs within one low clock phase. For the first pair it judges that the read returns the old flags and that a second read shows the new flag. For the second pair it checks that the written register takes the host byte over the old value while the other register takes the engine's value.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int NCH = 4;
  localparam int CHW = $clog2(NCH);
  localparam int RW  = 16;
  localparam int BW  = 8;

  typedef enum logic [3:0] {
    P_STATCMD = 4'h8,
    P_REQ     = 4'h9,
    P_SMASK   = 4'hA,
    P_MODE    = 4'hB,
    P_CLRPTR  = 4'hC,
    P_MCLR    = 4'hD,
    P_CLRMSK  = 4'hE,
    P_AMASK   = 4'hF
  } port_e;

  typedef enum logic [1:0] {
    XF_VERIFY = 2'b00,
    XF_WRITE  = 2'b01,
    XF_READ   = 2'b10
  } xfer_e;

  typedef struct packed {
    logic [1:0] opmode;
    logic       inc;
    logic       autoinit;
    logic [1:0] xfer;
  } mode_t;
endpackage

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs #(
  parameter int RW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr_addr,
  input  logic          host_wr_cnt,
  input  logic          hi_byte,
  input  logic [BW-1:0] wdata,
  input  logic          eng_upd,
  input  logic [RW-1:0] eng_addr,
  input  logic [RW-1:0] eng_cnt,
  output logic [RW-1:0] base_addr,
  output logic [RW-1:0] base_cnt,
  output logic [RW-1:0] cur_addr,
  output logic [RW-1:0] cur_cnt
);
  function automatic logic [RW-1:0] put_byte(input logic [RW-1:0] old,
                                             input logic [BW-1:0] b,
                                             input logic hi);
    return hi ? {b, old[RW-BW-1:0]} : {old[RW-1:BW], b};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_cnt   <= '0;
    end else begin
      if (host_wr_addr) begin
        base_addr <= put_byte(base_addr, wdata, hi_byte);
        cur_addr  <= put_byte(cur_addr, wdata, hi_byte);
      end else if (eng_upd) begin
        cur_addr <= eng_addr;
      end
      if (host_wr_cnt) begin
        base_cnt <= put_byte(base_cnt, wdata, hi_byte);
        cur_cnt  <= put_byte(cur_cnt, wdata, hi_byte);
      end else if (eng_upd) begin
        cur_cnt <= eng_cnt;
      end
    end
  end

  // R2
  lo_byte_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_addr && !hi_byte) |=> (cur_addr[BW-1:0] == $past(wdata)) &&
                                   (base_addr[BW-1:0] == $past(wdata)));
  // R10
  eng_upd_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_upd && !host_wr_cnt) |=> (cur_cnt == $past(eng_cnt)) && $stable(base_cnt));
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [3:0]     io_addr,
  input  logic           io_wr,
  input  logic           io_rd,
  input  logic [BW-1:0]  io_wdata,
  input  logic [NCH-1:0] eng_tc,
  input  logic [NCH-1:0] eng_hwreq,
  output logic           ptr_hi,
  output logic [BW-1:0]  cmd_q,
  output mode_t          mode_q [NCH],
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] swreq_q,
  output logic [BW-1:0]  status
);
  logic [NCH-1:0] tc_q;
  logic acc16, mclr, clrptr, stat_rd;
  logic [CHW-1:0] sel;

  assign acc16   = (io_wr || io_rd) && !io_addr[3];
  assign mclr    = io_wr && (io_addr == P_MCLR);
  assign clrptr  = io_wr && (io_addr == P_CLRPTR);
  assign stat_rd = io_rd && (io_addr == P_STATCMD);
  assign sel     = io_wdata[CHW-1:0];
  assign status  = {swreq_q | eng_hwreq, tc_q};

  always_ff @(posedge clk) begin
    if (!rst_n || mclr) begin
      ptr_hi <= 1'b0;
    end else if (clrptr) begin
      ptr_hi <= 1'b0;
    end else if (acc16) begin
      ptr_hi <= ~ptr_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || mclr) begin
      cmd_q   <= '0;
      mask_q  <= '1;
      swreq_q <= '0;
      tc_q    <= '0;
    end else begin
      if (io_wr && io_addr == P_STATCMD) cmd_q <= io_wdata;
      if (io_wr && io_addr == P_CLRMSK) mask_q <= '0;
      else if (io_wr && io_addr == P_SMASK) mask_q[sel] <= io_wdata[2];
      else if (io_wr && io_addr == P_AMASK) mask_q <= io_wdata[NCH-1:0];
      if (io_wr && io_addr == P_REQ) swreq_q[sel] <= io_wdata[2];
      tc_q <= (stat_rd ? '0 : tc_q) | eng_tc;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_mode
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode_q[i] <= '0;
      end else if (io_wr && io_addr == P_MODE && sel == CHW'(i)) begin
        mode_q[i] <= {io_wdata[7:6], io_wdata[5], io_wdata[4], io_wdata[3:2]};
      end
    end
  end

  // R3
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc16 |=> ptr_hi != $past(ptr_hi));
  // R4
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clrptr |=> !ptr_hi);
  // R5
  mclr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mclr |=> (mask_q == '1) && (cmd_q == '0) && (tc_q == '0));
  // R9
  tc_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|eng_tc && !mclr) |=> ((tc_q & $past(eng_tc)) == $past(eng_tc)));
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
  import dmac_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [BW-1:0]     io_wdata,
  output logic [BW-1:0]     io_rdata,
  output logic [BW-1:0]     cfg_cmd,
  output logic [2*NCH-1:0]  cfg_xfer,
  output logic [NCH-1:0]    cfg_auto,
  output logic [NCH-1:0]    cfg_inc,
  output logic [2*NCH-1:0]  cfg_opmode,
  output logic [NCH-1:0]    ch_mask,
  output logic [NCH-1:0]    ch_swreq,
  output logic [RW*NCH-1:0] ch_base_addr,
  output logic [RW*NCH-1:0] ch_base_cnt,
  output logic [RW*NCH-1:0] ch_cur_addr,
  output logic [RW*NCH-1:0] ch_cur_cnt,
  input  logic [NCH-1:0]    eng_upd,
  input  logic [RW*NCH-1:0] eng_addr,
  input  logic [RW*NCH-1:0] eng_cnt,
  input  logic [NCH-1:0]    eng_tc,
  input  logic [NCH-1:0]    eng_hwreq
);
  logic          ptr_hi;
  mode_t         mode_q [NCH];
  logic [BW-1:0] status;
  logic [CHW-1:0] rd_ch;
  logic [RW-1:0]  rd_val;

  dmac_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .eng_tc(eng_tc), .eng_hwreq(eng_hwreq),
    .ptr_hi(ptr_hi), .cmd_q(cfg_cmd), .mode_q(mode_q), .mask_q(ch_mask),
    .swreq_q(ch_swreq), .status(status)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic wr_sel;
    assign wr_sel = io_wr && !io_addr[3] && (io_addr[CHW:1] == CHW'(i));

    dmac_chan_regs #(.RW(RW), .BW(BW)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .host_wr_addr(wr_sel && !io_addr[0]),
      .host_wr_cnt(wr_sel && io_addr[0]),
      .hi_byte(ptr_hi), .wdata(io_wdata),
      .eng_upd(eng_upd[i]),
      .eng_addr(eng_addr[i*RW +: RW]), .eng_cnt(eng_cnt[i*RW +: RW]),
      .base_addr(ch_base_addr[i*RW +: RW]), .base_cnt(ch_base_cnt[i*RW +: RW]),
      .cur_addr(ch_cur_addr[i*RW +: RW]), .cur_cnt(ch_cur_cnt[i*RW +: RW])
    );

    assign cfg_xfer[2*i +: 2]   = (mode_q[i].xfer == 2'b11) ? XF_VERIFY : mode_q[i].xfer;
    assign cfg_auto[i]          = mode_q[i].autoinit;
    assign cfg_inc[i]           = mode_q[i].inc;
    assign cfg_opmode[2*i +: 2] = mode_q[i].opmode;
  end

  assign rd_ch  = io_addr[CHW:1];
  assign rd_val = io_addr[0] ? ch_cur_cnt[rd_ch*RW +: RW] : ch_cur_addr[rd_ch*RW +: RW];

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      if (!io_addr[3]) io_rdata = ptr_hi ? rd_val[RW-1:BW] : rd_val[BW-1:0];
      else if (io_addr == P_STATCMD) io_rdata = status;
    end
  end

  // R9
  stat_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == P_STATCMD) |-> (io_rdata[2*NCH-1:NCH] == (ch_swreq | eng_hwreq)));
endmodule

// File: tb/sim_dmac_regfile.sv
module sim_dmac_regfile;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] io_addr = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata, cfg_cmd;
  logic [7:0] cfg_xfer, cfg_opmode;
  logic [3:0] cfg_auto, cfg_inc, ch_mask, ch_swreq;
  logic [63:0] ch_base_addr, ch_base_cnt, ch_cur_addr, ch_cur_cnt;
  logic [3:0] eng_upd = '0, eng_tc = '0, eng_hwreq = '0;
  logic [63:0] eng_addr = '0, eng_cnt = '0;
  int checks = 0, errors = 0;
  logic [7:0] rb;

  always #4 clk = ~clk;

  dmac_regfile u0 (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); io_addr = a; io_rd = 1'b1; #1 d = io_rdata;
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 mask", ch_mask, 4'hF);
    chk("R1 cmd", cfg_cmd, 0);
    chk("R1 swreq", ch_swreq, 0);
    chk("R1 regs", ch_cur_addr | ch_base_cnt, 0);
    rd(4'h8, rb); chk("R1 status", rb, 0);
  endtask

  task automatic t_prog;
    wr(4'hC, 0);
    wr(4'h4, 8'h34); wr(4'h4, 8'h12);
    chk("R2 ch2 base addr", ch_base_addr[32 +: 16], 16'h1234);
    chk("R2 ch2 cur addr", ch_cur_addr[32 +: 16], 16'h1234);
    wr(4'h7, 8'hCD); wr(4'h7, 8'hAB);
    chk("R2 ch3 cnt", {ch_base_cnt[48 +: 16], ch_cur_cnt[48 +: 16]}, 32'hABCDABCD);
    wr(4'h1, 8'h22); wr(4'h1, 8'h33);
    rd(4'h4, rb); chk("R3 lo read", rb, 8'h34);
    rd(4'h4, rb); chk("R3 hi read", rb, 8'h12);
  endtask

  task automatic t_ptr;
    wr(4'hC, 0);
    wr(4'h0, 8'h11);
    rd(4'h1, rb); chk("R3 shared pointer", rb, 8'h33);
    rd(4'h4, rb); chk("R3 after toggle", rb, 8'h34);
    wr(4'hC, 0);
    rd(4'h4, rb); chk("R4 clear pointer", rb, 8'h34);
    wr(4'hC, 0);
  endtask

  task automatic t_masks;
    wr(4'hE, 8'h00); chk("R6 clear all", ch_mask, 4'h0);
    wr(4'hA, 8'h05); chk("R6 single set", ch_mask, 4'h2);
    wr(4'hF, 8'h09); chk("R6 all write", ch_mask, 4'h9);
    wr(4'hA, 8'h00); chk("R6 single clear", ch_mask, 4'h8);
  endtask

  task automatic t_req;
    wr(4'h9, 8'h06); chk("R7 swreq set", ch_swreq, 4'h4);
    rd(4'h8, rb); chk("R9 pending sw", rb, 8'h40);
    eng_hwreq = 4'h1;
    rd(4'h8, rb); chk("R9 pending hw", rb, 8'h50);
    eng_hwreq = 4'h0;
    wr(4'h9, 8'h02); chk("R7 swreq clear", ch_swreq, 4'h0);
  endtask

  task automatic t_mode;
    wr(4'hB, 8'b10_1_1_11_01);
    chk("R8 type 11 as verify", cfg_xfer[3:2], 2'b00);
    chk("R8 auto/inc/mode ch1", {cfg_auto[1], cfg_inc[1], cfg_opmode[3:2]}, 4'b1110);
    wr(4'hB, 8'b01_0_0_01_10);
    chk("R8 ch2 fields", {cfg_xfer[5:4], cfg_auto[2], cfg_inc[2], cfg_opmode[5:4]}, 6'b01_0_0_01);
  endtask

  task automatic t_cmd;
    wr(4'h8, 8'hA5); chk("R11 command", cfg_cmd, 8'hA5);
  endtask

  task automatic t_tc;
    @(negedge clk); eng_tc = 4'h8; @(negedge clk); eng_tc = 4'h0;
    rd(4'h8, rb); chk("R9 tc flag", rb, 8'h08);
    rd(4'h8, rb); chk("R9 tc cleared by read", rb, 8'h00);
    @(negedge clk); io_addr = 4'h8; io_rd = 1'b1; eng_tc = 4'h2; #1 rb = io_rdata;
    @(negedge clk); io_rd = 1'b0; eng_tc = 4'h0;
    chk("R9 same-cycle read old", rb, 8'h00);
    rd(4'h8, rb); chk("R9 same-cycle tc kept", rb, 8'h02);
  endtask

  task automatic t_engine;
    logic [15:0] b0;
    b0 = ch_base_addr[15:0];
    @(negedge clk); eng_upd = 4'h1; eng_addr[15:0] = 16'hBEEF; eng_cnt[15:0] = 16'h0042;
    @(negedge clk); eng_upd = 4'h0;
    chk("R10 update cur", {ch_cur_addr[15:0], ch_cur_cnt[15:0]}, 32'hBEEF0042);
    chk("R10 base kept", ch_base_addr[15:0], b0);
    wr(4'hC, 0);
    @(negedge clk); io_addr = 4'h0; io_wdata = 8'h77; io_wr = 1'b1;
    eng_upd = 4'h1; eng_addr[15:0] = 16'h5555; eng_cnt[15:0] = 16'h6666;
    @(negedge clk); io_wr = 1'b0; eng_upd = 4'h0;
    chk("R10 host wins addr", ch_cur_addr[15:0], 16'hBE77);
    chk("R10 engine count", ch_cur_cnt[15:0], 16'h6666);
  endtask

  task automatic t_mclr;
    wr(4'hE, 0); wr(4'h9, 8'h07); wr(4'h8, 8'h3C);
    @(negedge clk); eng_tc = 4'h1; @(negedge clk); eng_tc = 4'h0;
    wr(4'hB, 8'h80);
    wr(4'hD, 8'h00);
    chk("R5 masks set", ch_mask, 4'hF);
    chk("R5 cmd/swreq", {cfg_cmd, ch_swreq}, 12'h000);
    chk("R5 mode kept", cfg_opmode[1:0], 2'b10);
    wr(4'h6, 8'hAA); wr(4'h6, 8'hBB);
    chk("R5 pointer low", ch_cur_addr[48 +: 16], 16'hBBAA);
    rd(4'h8, rb); chk("R5 status cleared", rb, 8'h00);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_prog();
    t_ptr();
    t_masks();
    t_req();
    t_mode();
    t_cmd();
    t_tc();
    t_engine();
    t_mclr();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule